// File: doc/BRIEF.md
# Dual-Source 128-bit Lane Permuter

This block assembles a 256-bit result from two 256-bit source vectors. It takes an 8-bit control byte, and each 128-bit half of the result draws on its own from one of the four 128-bit lanes the two sources offer. A separate control bit forces each half to zero, and the zero bit wins over the lane choice. The block also looks at two encoding qualifier bits, a length bit and a width bit. When either one is illegal, the block raises an invalid-opcode flag instead of updating its data.

Each operation arrives with a one-cycle `in_valid` strobe. The result and `out_valid` are registered and appear on the next clock. There is no back-pressure. Only integer bits move, so no arithmetic status of any kind comes out of the block.

Top module: `lane_permuter`

## Requirements
- R1: The low result half (bits 127:0) takes the source lane chosen by control bits [1:0]. The encoding is 0 = src_a[127:0], 1 = src_a[255:128], 2 = src_b[127:0], 3 = src_b[255:128].
- R2: The high result half (bits 255:128) takes the source lane chosen by control bits [5:4], with the same encoding as R1.
- R3: When control bit 3 is 1, the low result half is zero whatever bits [1:0] say.
- R4: When control bit 7 is 1, the high result half is zero whatever bits [5:4] say.
- R5: Control bits 2 and 6 have no effect on the result.
- R6: The operation is invalid when len_q is 0 or when wid_q is 1. In that case bad_op is 1 in the out_valid cycle and the result keeps its previous value.
- R7: out_valid is 1 exactly in the cycle after an in_valid cycle. bad_op is 0 for legal operations. bad_op and the result hold when no operation is issued.
- R8: A synchronous active-high reset clears out_valid, bad_op and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| ctrl | input | 8 | Lane-select and zero control byte |
| len_q | input | 1 | Vector-length qualifier (must be 1) |
| wid_q | input | 1 | Width qualifier (must be 0) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| bad_op | output | 1 | Invalid-opcode flag |
| result | output | 256 | Permuted result |

## Verification
Lane selection and forced zeroing can land on the same half in one operation. Every one of the 256 control values is swept, so each zero bit is set against all four lane codes. Each result is judged against a lane model computed in the bench. Invalid-qualifier operations are mixed in right after a known result, which checks that the flag and the hold of the old result appear together in a single cycle.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;
    localparam int LANE_W  = 128;
    localparam int LANES   = 2;
    localparam int VEC_W   = LANE_W * LANES;
    localparam int SEL_W   = 2;
    localparam int CTRL_W  = 8;

    typedef struct packed {
        logic             vld;
        logic             bad;
        logic [VEC_W-1:0] res;
    } perm_state_t;
endpackage

// File: rtl/lane_half_mux.sv
module lane_half_mux #(
    parameter int LANE_W = 128
) (
    input  logic [2*LANE_W-1:0] src_a,
    input  logic [2*LANE_W-1:0] src_b,
    input  logic [1:0]          sel,
    input  logic                zero,
    output logic [LANE_W-1:0]   half
);
    logic [LANE_W-1:0] picked;

    always_comb begin
        unique case (sel)
            2'd0:    picked = src_a[LANE_W-1:0];
            2'd1:    picked = src_a[2*LANE_W-1:LANE_W];
            2'd2:    picked = src_b[LANE_W-1:0];
            default: picked = src_b[2*LANE_W-1:LANE_W];
        endcase
        half = zero ? '0 : picked;
    end
endmodule

// File: rtl/lane_permuter.sv
module lane_permuter
    import lane_perm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              len_q,
    input  logic              wid_q,
    output logic              out_valid,
    output logic              bad_op,
    output logic [VEC_W-1:0]  result
);
    perm_state_t st_d, st_q;
    logic [VEC_W-1:0] perm_vec;

    // Half h uses select bits [4h+1:4h] and zero bit 4h+3.
    for (genvar h = 0; h < LANES; h++) begin : g_half
        lane_half_mux #(.LANE_W(LANE_W)) u_mux (
            .src_a (src_a),
            .src_b (src_b),
            .sel   (ctrl[4*h +: SEL_W]),
            .zero  (ctrl[4*h+3]),
            .half  (perm_vec[h*LANE_W +: LANE_W])
        );
    end

    logic illegal;
    assign illegal = !len_q || wid_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.bad = illegal;
            if (!illegal) st_d.res = perm_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign bad_op    = st_q.bad;
    assign result    = st_q.res;

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_only_after_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_bad_holds_result_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (!len_q || wid_q)) |=> (bad_op && $stable(result)));
    assert_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && len_q && !wid_q && ctrl[3]) |=> (result[LANE_W-1:0] == '0));
    assert_high_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && len_q && !wid_q && ctrl[7]) |=> (result[VEC_W-1:LANE_W] == '0));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(bad_op)));
endmodule

// File: tb/lane_permuter_test.sv
module lane_permuter_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1, in_valid = 0, len_q = 1, wid_q = 0;
    logic [255:0] src_a = '0, src_b = '0;
    logic [7:0] ctrl = '0;
    logic out_valid, bad_op;
    logic [255:0] result;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_permuter uut (.clk, .rst, .in_valid, .src_a, .src_b, .ctrl,
                       .len_q, .wid_q, .out_valid, .bad_op, .result);

    function automatic logic [127:0] lane(input logic [255:0] a, b, input logic [1:0] s);
        case (s)
            2'd0: return a[127:0];
            2'd1: return a[255:128];
            2'd2: return b[127:0];
            default: return b[255:128];
        endcase
    endfunction

    function automatic logic [255:0] model(input logic [255:0] a, b, input logic [7:0] c);
        logic [127:0] lo, hi;
        lo = c[3] ? 128'd0 : lane(a, b, c[1:0]);
        hi = c[7] ? 128'd0 : lane(a, b, c[5:4]);
        return {hi, lo};
    endfunction

    task automatic check(input string req, input logic [255:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    // drive at negedge, sample at following negedge (one posedge later)
    task automatic issue(input logic [255:0] a, b, input logic [7:0] c, input logic l, w);
        src_a = a; src_b = b; ctrl = c; len_q = l; wid_q = w; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [255:0] a, b, prev;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R8 reset out_valid", {255'd0, out_valid}, 256'd0);
        check("R8 reset bad_op", {255'd0, bad_op}, 256'd0);
        check("R8 reset result", result, 256'd0);

        // R1 R2 R3 R4: full sweep
        for (int c = 0; c < 256; c++) begin
            a = rnd256(); b = rnd256();
            issue(a, b, c[7:0], 1'b1, 1'b0);
            check("R1/R2/R3/R4 result", result, model(a, b, c[7:0]));
            check("R7 out_valid", {255'd0, out_valid}, 256'd1);
            check("R7 bad_op low", {255'd0, bad_op}, 256'd0);
            @(negedge clk);
            check("R7 out_valid drop", {255'd0, out_valid}, 256'd0);
        end

        // R5: bits 2 and 6 ignored
        for (int c = 0; c < 256; c++) begin
            logic [255:0] r0;
            a = rnd256(); b = rnd256();
            issue(a, b, c[7:0] & 8'hBB, 1'b1, 1'b0);
            r0 = result;
            issue(a, b, c[7:0] | 8'h44, 1'b1, 1'b0);
            check("R5 ignored bits", result, r0);
        end

        // R6: invalid qualifiers, back-to-back after a known result
        for (int k = 0; k < 3; k++) begin
            a = rnd256(); b = rnd256();
            issue(a, b, 8'h21, 1'b1, 1'b0);
            prev = result;
            issue(rnd256(), rnd256(), 8'h10, (k == 1), (k != 0));
            check("R6 bad_op set", {255'd0, bad_op}, 256'd1);
            check("R6 out_valid", {255'd0, out_valid}, 256'd1);
            check("R6 result held", result, prev);
            @(negedge clk);
            check("R7 bad_op held idle", {255'd0, bad_op}, 256'd1);
            check("R7 result held idle", result, prev);
            issue(a, b, 8'h30, 1'b1, 1'b0);
            check("R6 bad_op cleared", {255'd0, bad_op}, 256'd0);
            check("R6 result after legal", result, model(a, b, 8'h30));
        end

        // R8: reset mid-stream
        issue(rnd256(), rnd256(), 8'h13, 1'b1, 1'b0);
        rst = 1; @(negedge clk); rst = 0;
        check("R8 reset clears result", result, 256'd0);
        check("R8 reset clears valid", {255'd0, out_valid}, 256'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule